// File: doc/BRIEF.md
# Dataflow ALU Operation Cell

This block is one arithmetic and logic element of a coarse-grained reconfigurable array. Three operand channels arrive on each cycle: two data words (A and B) and a single carry or condition bit (C). Each channel has its own valid strobe. A static configuration selects the operation, the operand width, an immediate value and a terminal count. The cell fires in the cycle in which every operand the selected operation needs is valid. One clock later it presents a data result and a one-bit flag, and each output has its own valid strobe.

The operation set covers several groups. It has addition and subtraction, with and without a carry or borrow input. It has bitwise logic and an any-bit-set reduction. It has single-position shifts and rotations, including rotations through the carry. It has sign and zero extension and a swap. It has pass-through, immediate store and a no-operation code, signed, unsigned and equality comparisons, and an event counter. It also has three steering operations: a conditional gate, a two-input join and a two-way select. Each operation accepts only some of the three widths: full word, low byte and single bit. A combination it does not accept never fires.

Top module: `alu_cell`

## Requirements
- R1: The outputs y_vld and f_vld rise for exactly one cycle, on the clock after a cycle in which A is valid and every other operand the operation needs is valid. No output is produced otherwise. B is needed by add, add-with-carry, subtract, subtract-with-borrow, AND, OR, XOR, the four ordered comparisons, equality, join and select. C is needed by add-with-carry, subtract-with-borrow, both rotate-through-carry operations, gate and select. An operand that is not needed is ignored.
- R2: Operation codes on cfg_op are: 0 nop, 1 pass, 2 immediate, 3 add, 4 add-carry, 5 sub, 6 sub-borrow, 7 AND, 8 OR, 9 XOR, 10 NOT, 11 any-bit, 12 arith-left, 13 arith-right, 14 logic-left, 15 logic-right, 16 rotate-left, 17 rotate-right, 18 rotate-left-through-C, 19 rotate-right-through-C, 20 sign-extend, 21 zero-extend, 22 swap, 23 signed ≥, 24 unsigned ≥, 25 signed >, 26 unsigned >, 27 equal, 28 count, 29 gate, 30 join, 31 select. Width codes on cfg_width are 0 full, 1 byte (low half) and 2 bit (bit 0); code 3 is reserved. A code/width pair that is not allowed never produces output and does not advance the counter. Byte and bit results are zero above their width unless the operation says otherwise.
- R3: Add and subtract (codes 3 to 6) run at full or byte width. Add-with-carry adds c_bit, and subtract-with-borrow also subtracts c_bit. The flag is the carry out of the top bit of the selected width for additions. For subtractions it is 1 when a borrow occurs.
- R4: AND, OR, XOR and NOT accept all three widths. In bit mode the flag equals the result bit, and otherwise it is 0. The any-bit code accepts full and byte widths and returns 1 in both y and the flag when any bit of A within the width is set.
- R5: Shift and rotate codes (12 to 19) accept full width only and move A by one position. The flag is the bit that leaves A. Left arithmetic and left logic shifts insert 0. Right arithmetic shift copies the top bit and right logic shift inserts 0. Plain rotations wrap the leaving bit around. The through-C rotations insert c_bit.
- R6: Sign-extend, zero-extend and swap accept byte and bit widths, with flag 0. Byte mode extends the low half of A to a full word, or exchanges the two halves of A. Bit mode extends A bit 0 to a full word, or exchanges A bits 0 and 1 and keeps the upper bits.
- R7: Pass returns A trimmed to the width, with the flag equal to A bit 0 in bit mode and 0 otherwise. Immediate returns cfg_imm trimmed to the width, with flag 0, and is triggered by a valid A. Nop never produces output.
- R8: Comparisons (codes 23 to 27) accept full and byte widths. They return the boolean result in y bit 0 (all other bits 0) and in the flag.
- R9: Count accepts full and byte widths. Each firing advances an internal CNT_W-bit count and outputs the new value. When the new value equals cfg_limit, the flag is 1 and the count restarts at 0.
- R10: Gate accepts full and byte widths. When c_bit is 1 it outputs A trimmed to the width, with flag 1. When c_bit is 0 it takes the operands and outputs nothing.
- R11: Join accepts full and byte widths and outputs A trimmed, with flag 0, only when A and B are both valid. Select accepts full and byte widths, outputs B when c_bit is 1 and A when it is 0, and sets the flag to c_bit.
- R12: While rst_n is low, all outputs are 0 and the count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_op | input | 5 | Operation code |
| cfg_width | input | 2 | Width code |
| cfg_imm | input | DATA_W | Immediate value |
| cfg_limit | input | CNT_W | Terminal count |
| a_dat | input | DATA_W | Operand A |
| a_vld | input | 1 | A valid |
| b_dat | input | DATA_W | Operand B |
| b_vld | input | 1 | B valid |
| c_bit | input | 1 | Carry / condition bit |
| c_vld | input | 1 | C valid |
| y_dat | output | DATA_W | Data result |
| y_vld | output | 1 | Data result valid |
| f_bit | output | 1 | Flag result |
| f_vld | output | 1 | Flag result valid |

## Verification
The directed patterns target the edges of each operation. All-ones plus one separates a carry that leaves the full word from one that leaves the low byte. Sign-bit operands show whether a comparison or extension is signed. Rotations through C with c_bit set show whether the inserted bit comes from C or from the wrapped bit. A terminal count run across the limit shows the wrap and the flag. A randomized sweep then draws every code with every width code, including the reserved one and disallowed pairs, and drops valid strobes independently. This tells apart the need sets of the operations, the legal widths, and the gate's silent consumption.

// File: rtl/alu_cell_pkg.sv
package alu_cell_pkg;

   typedef enum logic [4:0] {
      OP_NOP   = 5'd0,  OP_PASS  = 5'd1,  OP_IMM   = 5'd2,  OP_ADD   = 5'd3,
      OP_ADDC  = 5'd4,  OP_SUB   = 5'd5,  OP_SUBB  = 5'd6,  OP_AND   = 5'd7,
      OP_OR    = 5'd8,  OP_XOR   = 5'd9,  OP_NOT   = 5'd10, OP_ANY   = 5'd11,
      OP_SHLA  = 5'd12, OP_SHRA  = 5'd13, OP_SHLL  = 5'd14, OP_SHRL  = 5'd15,
      OP_ROL   = 5'd16, OP_ROR   = 5'd17, OP_ROLC  = 5'd18, OP_RORC  = 5'd19,
      OP_SEXT  = 5'd20, OP_ZEXT  = 5'd21, OP_SWAP  = 5'd22, OP_GES   = 5'd23,
      OP_GEU   = 5'd24, OP_GTS   = 5'd25, OP_GTU   = 5'd26, OP_EQ    = 5'd27,
      OP_COUNT = 5'd28, OP_GATE  = 5'd29, OP_JOIN  = 5'd30, OP_SEL   = 5'd31
   } op_e;

   typedef enum logic [1:0] {
      W_FULL = 2'd0,
      W_BYTE = 2'd1,
      W_BIT  = 2'd2,
      W_RSVD = 2'd3
   } wid_e;

endpackage

// File: rtl/alu_cell_decode.sv
module alu_cell_decode
   import alu_cell_pkg::*;
(
   input  op_e  op,
   input  wid_e wid,
   output logic legal,
   output logic need_b,
   output logic need_c
);

   logic w_fb;
   assign w_fb = (wid == W_FULL) || (wid == W_BYTE);

   always_comb begin
      legal  = 1'b0;
      need_b = 1'b0;
      need_c = 1'b0;
      case (op)
         OP_NOP:                     legal = 1'b0;
         OP_PASS, OP_IMM, OP_NOT:    legal = (wid != W_RSVD);
         OP_AND, OP_OR, OP_XOR: begin
            legal  = (wid != W_RSVD);
            need_b = 1'b1;
         end
         OP_ADD, OP_SUB: begin
            legal  = w_fb;
            need_b = 1'b1;
         end
         OP_ADDC, OP_SUBB: begin
            legal  = w_fb;
            need_b = 1'b1;
            need_c = 1'b1;
         end
         OP_ANY, OP_COUNT:           legal = w_fb;
         OP_SHLA, OP_SHRA, OP_SHLL, OP_SHRL, OP_ROL, OP_ROR:
                                     legal = (wid == W_FULL);
         OP_ROLC, OP_RORC: begin
            legal  = (wid == W_FULL);
            need_c = 1'b1;
         end
         OP_SEXT, OP_ZEXT, OP_SWAP:  legal = (wid == W_BYTE) || (wid == W_BIT);
         OP_GES, OP_GEU, OP_GTS, OP_GTU, OP_EQ, OP_JOIN: begin
            legal  = w_fb;
            need_b = 1'b1;
         end
         OP_GATE: begin
            legal  = w_fb;
            need_c = 1'b1;
         end
         OP_SEL: begin
            legal  = w_fb;
            need_b = 1'b1;
            need_c = 1'b1;
         end
         default:                    legal = 1'b0;
      endcase
   end

endmodule

// File: rtl/alu_cell_count.sv
module alu_cell_count #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] nxt,
   output logic             hit
);

   logic [CNT_W-1:0] cnt_q;

   assign nxt = cnt_q + CNT_W'(1);
   assign hit = (nxt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (step)
         cnt_q <= hit ? '0 : nxt;
   end

endmodule

// File: rtl/alu_cell_dp.sv
module alu_cell_dp
   import alu_cell_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 8
) (
   input  op_e               op,
   input  wid_e              wid,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              c,
   input  logic [DATA_W-1:0] imm,
   input  logic [CNT_W-1:0]  cnt_nxt,
   input  logic              cnt_hit,
   output logic [DATA_W-1:0] y,
   output logic              f,
   output logic              shut
);

   localparam int DW = DATA_W;
   localparam int HW = DATA_W / 2;

   function automatic logic [DW-1:0] fit(input logic [DW-1:0] v, input wid_e w);
      case (w)
         W_BYTE:  fit = {{HW{1'b0}}, v[HW-1:0]};
         W_BIT:   fit = DW'(v[0]);
         default: fit = v;
      endcase
   endfunction

   logic          ci;
   logic [DW:0]   sum_f, dif_f;
   logic [HW:0]   sum_h, dif_h;
   logic          is_byte;
   logic          ge_s, ge_u, gt_s, gt_u, eq;
   logic [DW-1:0] lg;

   assign is_byte = (wid == W_BYTE);
   assign ci      = ((op == OP_ADDC) || (op == OP_SUBB)) ? c : 1'b0;
   assign sum_f   = {1'b0, a} + {1'b0, b} + (DW+1)'(ci);
   assign dif_f   = {1'b0, a} - {1'b0, b} - (DW+1)'(ci);
   assign sum_h   = {1'b0, a[HW-1:0]} + {1'b0, b[HW-1:0]} + (HW+1)'(ci);
   assign dif_h   = {1'b0, a[HW-1:0]} - {1'b0, b[HW-1:0]} - (HW+1)'(ci);

   always_comb begin
      if (is_byte) begin
         ge_s = $signed(a[HW-1:0]) >= $signed(b[HW-1:0]);
         gt_s = $signed(a[HW-1:0]) >  $signed(b[HW-1:0]);
         ge_u = a[HW-1:0] >= b[HW-1:0];
         gt_u = a[HW-1:0] >  b[HW-1:0];
         eq   = a[HW-1:0] == b[HW-1:0];
      end else begin
         ge_s = $signed(a) >= $signed(b);
         gt_s = $signed(a) >  $signed(b);
         ge_u = a >= b;
         gt_u = a >  b;
         eq   = a == b;
      end
   end

   always_comb begin
      case (op)
         OP_AND:  lg = a & b;
         OP_OR:   lg = a | b;
         OP_XOR:  lg = a ^ b;
         default: lg = ~a;
      endcase
   end

   always_comb begin
      y    = '0;
      f    = 1'b0;
      shut = 1'b0;
      case (op)
         OP_PASS: begin
            y = fit(a, wid);
            f = (wid == W_BIT) & a[0];
         end
         OP_IMM:  y = fit(imm, wid);
         OP_ADD, OP_ADDC: begin
            y = is_byte ? DW'(sum_h[HW-1:0]) : sum_f[DW-1:0];
            f = is_byte ? sum_h[HW] : sum_f[DW];
         end
         OP_SUB, OP_SUBB: begin
            y = is_byte ? DW'(dif_h[HW-1:0]) : dif_f[DW-1:0];
            f = is_byte ? dif_h[HW] : dif_f[DW];
         end
         OP_AND, OP_OR, OP_XOR, OP_NOT: begin
            y = fit(lg, wid);
            f = (wid == W_BIT) & lg[0];
         end
         OP_ANY: begin
            f = is_byte ? |a[HW-1:0] : |a;
            y = DW'(f);
         end
         OP_SHLA, OP_SHLL: begin
            y = {a[DW-2:0], 1'b0};
            f = a[DW-1];
         end
         OP_SHRA: begin
            y = {a[DW-1], a[DW-1:1]};
            f = a[0];
         end
         OP_SHRL: begin
            y = {1'b0, a[DW-1:1]};
            f = a[0];
         end
         OP_ROL: begin
            y = {a[DW-2:0], a[DW-1]};
            f = a[DW-1];
         end
         OP_ROR: begin
            y = {a[0], a[DW-1:1]};
            f = a[0];
         end
         OP_ROLC: begin
            y = {a[DW-2:0], c};
            f = a[DW-1];
         end
         OP_RORC: begin
            y = {c, a[DW-1:1]};
            f = a[0];
         end
         OP_SEXT: y = is_byte ? {{HW{a[HW-1]}}, a[HW-1:0]} : {DW{a[0]}};
         OP_ZEXT: y = fit(a, wid);
         OP_SWAP: y = is_byte ? {a[HW-1:0], a[DW-1:HW]} : {a[DW-1:2], a[0], a[1]};
         OP_GES:  begin f = ge_s; y = DW'(ge_s); end
         OP_GEU:  begin f = ge_u; y = DW'(ge_u); end
         OP_GTS:  begin f = gt_s; y = DW'(gt_s); end
         OP_GTU:  begin f = gt_u; y = DW'(gt_u); end
         OP_EQ:   begin f = eq;   y = DW'(eq);   end
         OP_COUNT: begin
            y = DW'(cnt_nxt);
            f = cnt_hit;
         end
         OP_GATE: begin
            y    = fit(a, wid);
            f    = 1'b1;
            shut = ~c;
         end
         OP_JOIN: y = fit(a, wid);
         OP_SEL: begin
            y = fit(c ? b : a, wid);
            f = c;
         end
         default: begin
            y = '0;
            f = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/alu_cell.sv
module alu_cell
   import alu_cell_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [4:0]        cfg_op,
   input  logic [1:0]        cfg_width,
   input  logic [DATA_W-1:0] cfg_imm,
   input  logic [CNT_W-1:0]  cfg_limit,
   input  logic [DATA_W-1:0] a_dat,
   input  logic              a_vld,
   input  logic [DATA_W-1:0] b_dat,
   input  logic              b_vld,
   input  logic              c_bit,
   input  logic              c_vld,
   output logic [DATA_W-1:0] y_dat,
   output logic              y_vld,
   output logic              f_bit,
   output logic              f_vld
);

   generate
      if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("alu_cell: DATA_W must be even and at least 4");
      end
      if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_count
         $error("alu_cell: CNT_W must lie between 1 and DATA_W");
      end
   endgenerate

   op_e  op;
   wid_e wid;
   assign op  = op_e'(cfg_op);
   assign wid = wid_e'(cfg_width);

   logic legal, need_b, need_c;
   logic fire, emit, shut;
   logic [DATA_W-1:0] y_nxt;
   logic f_nxt;
   logic [CNT_W-1:0] cnt_nxt;
   logic cnt_hit;

   alu_cell_decode u_dec (
      .op     (op),
      .wid    (wid),
      .legal  (legal),
      .need_b (need_b),
      .need_c (need_c)
   );

   assign fire = legal & a_vld & (b_vld | ~need_b) & (c_vld | ~need_c);
   assign emit = fire & ~shut;

   alu_cell_count #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (fire && (op == OP_COUNT)),
      .limit (cfg_limit),
      .nxt   (cnt_nxt),
      .hit   (cnt_hit)
   );

   alu_cell_dp #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
      .op      (op),
      .wid     (wid),
      .a       (a_dat),
      .b       (b_dat),
      .c       (c_bit),
      .imm     (cfg_imm),
      .cnt_nxt (cnt_nxt),
      .cnt_hit (cnt_hit),
      .y       (y_nxt),
      .f       (f_nxt),
      .shut    (shut)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         y_vld <= 1'b0;
         f_vld <= 1'b0;
         y_dat <= '0;
         f_bit <= 1'b0;
      end else begin
         y_vld <= emit;
         f_vld <= emit;
         if (emit) begin
            y_dat <= y_nxt;
            f_bit <= f_nxt;
         end
      end
   end

endmodule

// File: rtl/alu_cell_chk.sv
module alu_cell_chk #(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [4:0]        cfg_op,
   input logic [1:0]        cfg_width,
   input logic              a_vld,
   input logic              c_bit,
   input logic              c_vld,
   input logic [DATA_W-1:0] y_dat,
   input logic              y_vld
);

   localparam int HW = DATA_W / 2;

   // R1: every operation needs A, so no valid A means no output next cycle
   a_r1_no_a_no_output: assert property (@(posedge clk) disable iff (!rst_n)
      !a_vld |=> !y_vld);

   // R2: reserved width code never fires
   a_r2_reserved_width: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_width == 2'd3) |=> !y_vld);

   // R3: byte-wide add/subtract results are clear in the upper half
   a_r3_byte_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_width == 2'd1 && cfg_op >= 5'd3 && cfg_op <= 5'd6)
         |=> (!y_vld || y_dat[DATA_W-1:HW] == '0));

   // R7: nop is silent
   a_r7_nop_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_op == 5'd0) |=> !y_vld);

   // R8: comparisons return a single boolean bit
   a_r8_cmp_boolean: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_op >= 5'd23 && cfg_op <= 5'd27)
         |=> (!y_vld || y_dat[DATA_W-1:1] == '0));

   // R10: a closed gate consumes without producing
   a_r10_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_op == 5'd29 && c_vld && !c_bit) |=> !y_vld);

endmodule

bind alu_cell alu_cell_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_alu_cell.sv
`timescale 1ns/1ps
module sim_alu_cell;

   localparam int DW = 16;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [4:0]    cfg_op;
   logic [1:0]    cfg_width;
   logic [DW-1:0] cfg_imm;
   logic [CW-1:0] cfg_limit;
   logic [DW-1:0] a_dat, b_dat;
   logic          a_vld, b_vld, c_bit, c_vld;
   logic [DW-1:0] y_dat;
   logic          y_vld, f_bit, f_vld;

   always #2.5 clk = ~clk;

   alu_cell #(.DATA_W(DW), .CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_op(cfg_op), .cfg_width(cfg_width),
      .cfg_imm(cfg_imm), .cfg_limit(cfg_limit),
      .a_dat(a_dat), .a_vld(a_vld), .b_dat(b_dat), .b_vld(b_vld),
      .c_bit(c_bit), .c_vld(c_vld),
      .y_dat(y_dat), .y_vld(y_vld), .f_bit(f_bit), .f_vld(f_vld)
   );

   int            n_cmp = 0;
   int            n_bad = 0;
   bit            done  = 0;
   logic          exp_v;
   logic [DW-1:0] exp_y;
   logic          exp_f;
   string         exp_tag;
   int            mcnt = 0;

   function automatic logic [DW-1:0] trim(input logic [DW-1:0] v, input int w);
      if (w == 1) return v & 16'h00FF;
      if (w == 2) return v & 16'h0001;
      return v;
   endfunction

   function automatic string tag_of(input int op);
      if (op <= 2)  return "R7";
      if (op <= 6)  return "R3";
      if (op <= 11) return "R4";
      if (op <= 19) return "R5";
      if (op <= 22) return "R6";
      if (op <= 27) return "R8";
      if (op == 28) return "R9";
      if (op == 29) return "R10";
      return "R11";
   endfunction

   // behavioural reference for the operands currently on the inputs
   task automatic predict();
      int op, w, s;
      bit lg, nb, nc, fb;
      logic [DW-1:0] a, b;
      logic c;
      op = int'(cfg_op); w = int'(cfg_width);
      a = a_dat; b = b_dat; c = c_bit;
      fb = (w == 0 || w == 1);
      lg = 0; nb = 0; nc = 0;
      if (op == 1 || op == 2 || op == 10) lg = (w < 3);
      if (op >= 7 && op <= 9) begin lg = (w < 3); nb = 1; end
      if (op >= 3 && op <= 6) begin lg = fb; nb = 1; nc = (op == 4 || op == 6); end
      if (op == 11 || op == 28) lg = fb;
      if (op >= 12 && op <= 19) begin lg = (w == 0); nc = (op >= 18); end
      if (op >= 20 && op <= 22) lg = (w == 1 || w == 2);
      if ((op >= 23 && op <= 27) || op == 30) begin lg = fb; nb = 1; end
      if (op == 29) begin lg = fb; nc = 1; end
      if (op == 31) begin lg = fb; nb = 1; nc = 1; end
      exp_y = '0; exp_f = 0;
      exp_tag = tag_of(op);
      exp_v = lg && a_vld && (!nb || b_vld) && (!nc || c_vld);
      if (!exp_v) begin
         exp_tag = lg ? "R1" : "R2";
         return;
      end
      case (op)
         1: begin exp_y = trim(a, w); exp_f = (w == 2) && a[0]; end
         2: exp_y = trim(cfg_imm, w);
         3, 4: begin
            if (w == 1) s = int'(a[7:0]) + int'(b[7:0]) + ((op == 4) ? int'(c) : 0);
            else        s = int'(a) + int'(b) + ((op == 4) ? int'(c) : 0);
            exp_y = trim(DW'(s), w);
            exp_f = (w == 1) ? s[8] : s[16];
         end
         5, 6: begin
            if (w == 1) s = int'(a[7:0]) - int'(b[7:0]) - ((op == 6) ? int'(c) : 0);
            else        s = int'(a) - int'(b) - ((op == 6) ? int'(c) : 0);
            exp_y = trim(DW'(s), w);
            exp_f = (s < 0);
         end
         7, 8, 9, 10: begin
            exp_y = trim((op == 7) ? (a & b) : (op == 8) ? (a | b) :
                         (op == 9) ? (a ^ b) : ~a, w);
            exp_f = (w == 2) && exp_y[0];
         end
         11: begin exp_f = (trim(a, w) != 0); exp_y = DW'(exp_f); end
         12, 14: begin exp_y = a << 1; exp_f = a[15]; end
         13: begin exp_y = {a[15], a[15:1]}; exp_f = a[0]; end
         15: begin exp_y = a >> 1; exp_f = a[0]; end
         16: begin exp_y = {a[14:0], a[15]}; exp_f = a[15]; end
         17: begin exp_y = {a[0], a[15:1]}; exp_f = a[0]; end
         18: begin exp_y = {a[14:0], c}; exp_f = a[15]; end
         19: begin exp_y = {c, a[15:1]}; exp_f = a[0]; end
         20: exp_y = (w == 1) ? {{8{a[7]}}, a[7:0]} : {16{a[0]}};
         21: exp_y = trim(a, w);
         22: exp_y = (w == 1) ? {a[7:0], a[15:8]} : {a[15:2], a[0], a[1]};
         23, 24, 25, 26, 27: begin
            int sa, sb, ua, ub;
            if (w == 1) begin
               sa = int'($signed(a[7:0])); sb = int'($signed(b[7:0]));
               ua = int'(a[7:0]); ub = int'(b[7:0]);
            end else begin
               sa = int'($signed(a)); sb = int'($signed(b));
               ua = int'(a); ub = int'(b);
            end
            case (op)
               23: exp_f = sa >= sb;
               24: exp_f = ua >= ub;
               25: exp_f = sa > sb;
               26: exp_f = ua > ub;
               default: exp_f = ua == ub;
            endcase
            exp_y = DW'(exp_f);
         end
         28: begin
            mcnt = (mcnt + 1) % 256;
            exp_y = DW'(mcnt);
            exp_f = (mcnt == int'(cfg_limit));
            if (exp_f) mcnt = 0;
         end
         29: begin
            exp_y = trim(a, w); exp_f = 1;
            if (!c) begin exp_v = 0; exp_tag = "R10"; end
         end
         30: exp_y = trim(a, w);
         default: begin exp_y = trim(c ? b : a, w); exp_f = c; end
      endcase
   endtask

   task automatic compare();
      n_cmp++;
      if (y_vld !== exp_v || f_vld !== exp_v) begin
         n_bad++;
         $display("FAIL %s valid: actual y_vld=%b f_vld=%b expected %b (op %0d w %0d)",
                  exp_tag, y_vld, f_vld, exp_v, cfg_op, cfg_width);
      end else if (exp_v) begin
         n_cmp++;
         if (y_dat !== exp_y || f_bit !== exp_f) begin
            n_bad++;
            $display("FAIL %s data: actual y=%h f=%b expected y=%h f=%b (op %0d w %0d)",
                     exp_tag, y_dat, f_bit, exp_y, exp_f, cfg_op, cfg_width);
         end
      end
   endtask

   task automatic step(input int op, input int w, input logic [DW-1:0] a,
                       input logic [DW-1:0] b, input logic c,
                       input logic av, input logic bv, input logic cv);
      cfg_op = 5'(op); cfg_width = 2'(w);
      a_dat = a; b_dat = b; c_bit = c;
      a_vld = av; b_vld = bv; c_vld = cv;
      predict();
      @(posedge clk);
      @(negedge clk);
      compare();
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      rst_n = 1'b0;
      cfg_op = '0; cfg_width = '0; cfg_imm = 16'hA5C3; cfg_limit = 8'd3;
      a_dat = '0; b_dat = '0; c_bit = 0; a_vld = 0; b_vld = 0; c_vld = 0;
      repeat (3) @(negedge clk);
      n_cmp++;
      if (y_vld !== 0 || f_vld !== 0 || y_dat !== 0 || f_bit !== 0) begin
         n_bad++;
         $display("FAIL R12 reset: actual y=%h yv=%b f=%b fv=%b expected all zero",
                  y_dat, y_vld, f_bit, f_vld);
      end
      rst_n = 1'b1;
      // R3 carry out of the full word and of the byte
      step(3, 0, 16'hFFFF, 16'h0001, 0, 1, 1, 0);
      step(3, 1, 16'h12FF, 16'h3401, 0, 1, 1, 0);
      step(4, 0, 16'h0001, 16'h0001, 1, 1, 1, 1);
      step(6, 1, 16'h0005, 16'h0007, 1, 1, 1, 1);
      step(4, 0, 16'h0001, 16'h0001, 1, 1, 1, 0);   // R1 missing C
      // R5 shifts and rotations
      step(13, 0, 16'h8001, 0, 0, 1, 0, 0);
      step(19, 0, 16'h0001, 0, 1, 1, 0, 1);
      step(18, 0, 16'h8000, 0, 1, 1, 0, 1);
      step(14, 1, 16'h0001, 0, 0, 1, 0, 0);         // R2 byte shift
      // R6 extension and swap
      step(20, 1, 16'h0080, 0, 0, 1, 0, 0);
      step(22, 1, 16'h1234, 0, 0, 1, 0, 0);
      step(22, 2, 16'h0002, 0, 0, 1, 0, 0);
      // R8 comparisons
      step(25, 1, 16'h0080, 16'h0001, 0, 1, 1, 0);
      step(26, 1, 16'h0080, 16'h0001, 0, 1, 1, 0);
      step(27, 0, 16'hBEEF, 16'hBEEF, 0, 1, 1, 0);
      // R4 logic
      step(8, 2, 16'h0000, 16'h0001, 0, 1, 1, 0);
      step(11, 1, 16'hFF00, 0, 0, 1, 0, 0);
      // R7 immediate, nop
      step(2, 0, 0, 0, 0, 1, 0, 0);
      step(0, 0, 16'h1111, 16'h2222, 1, 1, 1, 1);
      // R9 count across the limit
      for (int k = 0; k < 5; k++) step(28, 0, 0, 0, 0, 1, 0, 0);
      // R10 gate, R11 join / select
      step(29, 0, 16'h4321, 0, 0, 1, 0, 1);
      step(29, 0, 16'h4321, 0, 1, 1, 0, 1);
      step(30, 0, 16'h00AA, 16'h00BB, 0, 1, 0, 0);
      step(30, 1, 16'h77AA, 16'h00BB, 0, 1, 1, 0);
      step(31, 0, 16'h00AA, 16'h00BB, 1, 1, 1, 1);
      step(3, 3, 16'h0001, 16'h0001, 0, 1, 1, 0);   // R2 reserved width
      // randomized sweep
      for (int i = 0; i < 4000; i++) begin
         int w;
         cfg_limit = 8'($urandom_range(1, 4));
         cfg_imm = 16'($urandom);
         w = ($urandom_range(0, 9) == 0) ? 3 : $urandom_range(0, 2);
         step($urandom_range(0, 31), w, 16'($urandom), 16'($urandom),
              1'($urandom), ($urandom_range(0, 9) < 8), ($urandom_range(0, 9) < 8),
              ($urandom_range(0, 9) < 8));
      end
      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R1 watchdog: actual run still active, expected completion");
         summary();
         $finish;
      end
   end

endmodule